// File: doc/BRIEF.md
# Interrupt Entry Cycle Sequencer

This block sits beside the fetch stage of a small 8-bit core and owns the cycle-exact sequence that moves the core into an interrupt handler and back out of it. Requests from peripherals arrive as one-cycle pulses that set pending flags. When the core reports that an instruction has retired, the global enable is set and at least one flag is pending, the lowest-numbered source is taken. Over four stalled cycles the block writes the 16-bit return address onto a byte-wide stack, one byte every two cycles, clears the global enable and loads the fetch unit with that source's vector slot address. Because the response is always four cycles, a handler that reads a free-running timer sees a count that does not vary from one entry to the next.

The return path is driven by the core's return-from-interrupt strobe. It takes four cycles, the same as an ordinary return. It pops the two bytes in reverse order through a synchronous-read stack port, reloads the fetch address and sets the global enable again. The states are `ST_RUN` (normal execution), `ST_PUSH_LO`, `ST_PUSH_GAP`, `ST_PUSH_HI` and `ST_VEC_LOAD` (entry), and `ST_POP_HI`, `ST_POP_HI_CAP`, `ST_POP_LO` and `ST_RET_LOAD` (return). The transitions are: `ST_RUN`→`ST_PUSH_LO` on take, `ST_RUN`→`ST_POP_HI` on `reti_go`, and from there straight along each chain. `ST_VEC_LOAD` and `ST_RET_LOAD` go back to `ST_RUN`.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `sp` equals `SP_INIT` (0xFF by default), `gie` is 0, `fetch_stall` and `pc_load` are 0, and neither `stk_we` nor `stk_re` is asserted.
- R2: An interrupt is taken only in a `ST_RUN` cycle in which `insn_done` is 1, `gie` is 1 and a flag is pending. A request that arrives while a multi-cycle instruction is still running waits for that instruction's retire cycle.
- R3: Source i (bit i of `irq_req`) has vector number i+1. When several flags are pending, the lowest vector number is taken and only its flag is cleared. The others are taken on later entries in ascending order.
- R4: The four cycles after the take cycle all have `fetch_stall`=1. `pc_load` is 1 only in the fourth of them, with `next_pc` = (i+1)<<1 (word address of a 2-word vector slot). `fetch_stall` is 0 in the following cycle.
- R5: The first response cycle writes `cur_pc[7:0]`, as sampled in the take cycle, at address `sp`. The third writes `cur_pc[15:8]` at `sp`-1. `sp` decrements after each write, and the second and fourth cycles make no stack access.
- R6: `gie` drops to 0 at the end of the take cycle. No interrupt is taken while it is 0, and pending flags are kept. A `sei_go` pulse in `ST_RUN` sets it.
- R7: On `reti_go` in `ST_RUN`, four cycles with `fetch_stall`=1 follow. The first reads `sp`+1 (high byte) and the third reads `sp`+2 (low byte). Read data returns one cycle after the address. The fourth has `pc_load`=1 with `next_pc` = the popped address. Afterwards `sp` is 2 higher and `gie` is 1.
- R8: A request that becomes pending inside a handler is not taken during the return sequence, nor in `ST_RUN` cycles before the first `insn_done` after the return. It is taken at that first retire.
- R9: If the overflow of a timer clocked at the core clock coincides with a retire that takes its interrupt, a handler read made after a 2-cycle vector jump and 11 prologue cycles observes 17 counts.
- R10: `insn_done`, `sei_go` and `reti_go` pulses that arrive while `fetch_stall` is 1 have no effect. The stack contents, `sp` and `gie` come out as if those pulses were absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | One-cycle pulses that set pending flags |
| insn_done | input | 1 | An instruction retires this cycle |
| reti_go | input | 1 | Return-from-interrupt starts this cycle |
| sei_go | input | 1 | Set-global-enable instruction executes this cycle |
| cur_pc | input | 16 | Address of the next instruction to execute |
| stk_rdata | input | 8 | Stack read data, one cycle after the address |
| stk_we | output | 1 | Stack byte write |
| stk_re | output | 1 | Stack byte read |
| stk_addr | output | SP_W | Stack access address |
| stk_wdata | output | 8 | Stack write data |
| sp | output | SP_W | Stack pointer |
| gie | output | 1 | Global interrupt enable |
| next_pc | output | 16 | Address loaded into fetch |
| pc_load | output | 1 | Fetch takes `next_pc` this cycle |
| fetch_stall | output | 1 | Fetch is held |

## Verification
The bench sweeps every source with zero, one and two cycles of retire delay, and every mask of four simultaneous requests. A priority encoder built the wrong way round would take the wrong vector. A latency off by one would move `pc_load` away from the fourth response cycle and break the 17-count timer reading. The bench writes and reads a model stack memory, so swapped byte order or a misplaced pointer update gives a wrong return address. It also sends retire, enable and return pulses into the response window and makes requests while inside a handler. A design that listened to those pulses, or that took an interrupt before the interrupted program retired an instruction, would show extra stack traffic, a wrong `sp` or an early stall.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int PC_W   = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_PUSH_LO,
        ST_PUSH_GAP,
        ST_PUSH_HI,
        ST_VEC_LOAD,
        ST_POP_HI,
        ST_POP_HI_CAP,
        ST_POP_LO,
        ST_RET_LOAD
    } seq_state_e;

endpackage

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
    parameter int NUM_SRC = 4,
    parameter int IW      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic               take,
    output logic               any,
    output logic [IW-1:0]      win
);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;

    // lowest set bit as a one-hot grant
    always_comb begin
        grant = pend & (~pend + NUM_SRC'(1));
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend[g] <= 1'b0;
                end else if (req[g]) begin
                    pend[g] <= 1'b1;
                end else if (take && grant[g]) begin
                    pend[g] <= 1'b0;
                end
            end
        end
    endgenerate

    always_comb begin
        win = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win = IW'(i);
            end
        end
    end

    assign any = |pend;

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
    import irq_seq_pkg::*;
#(
    parameter int              SP_W    = 8,
    parameter logic [SP_W-1:0] SP_INIT = '1,
    parameter int              IW      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              reti_go,
    input  logic              sei_go,
    input  logic              any_pend,
    input  logic [IW-1:0]     win,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [BYTE_W-1:0] stk_rdata,
    output logic              take,
    output logic              stk_we,
    output logic              stk_re,
    output logic [SP_W-1:0]   stk_addr,
    output logic [BYTE_W-1:0] stk_wdata,
    output logic [SP_W-1:0]   sp,
    output logic              gie,
    output logic [PC_W-1:0]   next_pc,
    output logic              pc_load,
    output logic              fetch_stall
);

    localparam logic [SP_W-1:0] SP_STEP = SP_W'(1);

    seq_state_e        state, state_nx;
    logic [PC_W-1:0]   ret_pc;
    logic [IW-1:0]     vec_idx;
    logic [BYTE_W-1:0] hi_byte;
    logic [PC_W-1:0]   vec_pc;

    assign take = (state == ST_RUN) && !reti_go && insn_done && gie && any_pend;

    always_comb begin
        vec_pc = (PC_W'(vec_idx) + PC_W'(1)) << 1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (reti_go)   state_nx = ST_POP_HI;
                else if (take) state_nx = ST_PUSH_LO;
            end
            ST_PUSH_LO:    state_nx = ST_PUSH_GAP;
            ST_PUSH_GAP:   state_nx = ST_PUSH_HI;
            ST_PUSH_HI:    state_nx = ST_VEC_LOAD;
            ST_VEC_LOAD:   state_nx = ST_RUN;
            ST_POP_HI:     state_nx = ST_POP_HI_CAP;
            ST_POP_HI_CAP: state_nx = ST_POP_LO;
            ST_POP_LO:     state_nx = ST_RET_LOAD;
            ST_RET_LOAD:   state_nx = ST_RUN;
            default:       state_nx = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp      <= SP_INIT;
            gie     <= 1'b0;
            ret_pc  <= '0;
            vec_idx <= '0;
            hi_byte <= '0;
        end else begin
            if (take) begin
                ret_pc  <= cur_pc;
                vec_idx <= win;
                gie     <= 1'b0;
            end else if ((state == ST_RUN) && sei_go && !reti_go) begin
                gie <= 1'b1;
            end
            unique case (state)
                ST_PUSH_LO, ST_PUSH_HI: sp <= sp - SP_STEP;
                ST_POP_HI, ST_POP_LO:   sp <= sp + SP_STEP;
                ST_POP_HI_CAP:          hi_byte <= stk_rdata;
                ST_RET_LOAD:            gie <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        stk_we      = 1'b0;
        stk_re      = 1'b0;
        stk_addr    = sp;
        stk_wdata   = '0;
        pc_load     = 1'b0;
        next_pc     = '0;
        fetch_stall = (state != ST_RUN);
        unique case (state)
            ST_PUSH_LO: begin
                stk_we    = 1'b1;
                stk_wdata = ret_pc[BYTE_W-1:0];
            end
            ST_PUSH_HI: begin
                stk_we    = 1'b1;
                stk_wdata = ret_pc[PC_W-1:BYTE_W];
            end
            ST_POP_HI, ST_POP_LO: begin
                stk_re   = 1'b1;
                stk_addr = sp + SP_STEP;
            end
            ST_VEC_LOAD: begin
                pc_load = 1'b1;
                next_pc = vec_pc;
            end
            ST_RET_LOAD: begin
                pc_load = 1'b1;
                next_pc = {hi_byte, stk_rdata};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int              NUM_SRC = 4,
    parameter int              SP_W    = 8,
    parameter logic [SP_W-1:0] SP_INIT = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               insn_done,
    input  logic               reti_go,
    input  logic               sei_go,
    input  logic [15:0]        cur_pc,
    input  logic [7:0]         stk_rdata,
    output logic               stk_we,
    output logic               stk_re,
    output logic [SP_W-1:0]    stk_addr,
    output logic [7:0]         stk_wdata,
    output logic [SP_W-1:0]    sp,
    output logic               gie,
    output logic [15:0]        next_pc,
    output logic               pc_load,
    output logic               fetch_stall
);

    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic          take;
    logic          any_pend;
    logic [IW-1:0] win;

    irq_pend_arb #(
        .NUM_SRC (NUM_SRC),
        .IW      (IW)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_req),
        .take  (take),
        .any   (any_pend),
        .win   (win)
    );

    irq_seq_ctrl #(
        .SP_W    (SP_W),
        .SP_INIT (SP_INIT),
        .IW      (IW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_done   (insn_done),
        .reti_go     (reti_go),
        .sei_go      (sei_go),
        .any_pend    (any_pend),
        .win         (win),
        .cur_pc      (cur_pc),
        .stk_rdata   (stk_rdata),
        .take        (take),
        .stk_we      (stk_we),
        .stk_re      (stk_re),
        .stk_addr    (stk_addr),
        .stk_wdata   (stk_wdata),
        .sp          (sp),
        .gie         (gie),
        .next_pc     (next_pc),
        .pc_load     (pc_load),
        .fetch_stall (fetch_stall)
    );

endmodule

// File: rtl/irq_seq_checker.sv
module irq_seq_checker #(
    parameter int SP_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            insn_done,
    input logic            stk_we,
    input logic            stk_re,
    input logic [SP_W-1:0] sp,
    input logic            gie,
    input logic            pc_load,
    input logic            fetch_stall
);

    assert_load_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> fetch_stall);

    assert_entry_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && !$past(fetch_stall)) |-> ##3 pc_load);

    assert_take_on_retire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && !$past(fetch_stall)) |-> ($past(insn_done) && $past(gie)));

    assert_gie_low_in_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |-> !gie);

    assert_sp_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |=> (sp == $past(sp) - SP_W'(1)));

    assert_sp_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stk_re |=> (sp == $past(sp) + SP_W'(1)));

    assert_port_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stk_we, stk_re}));

    assert_access_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we || stk_re) |-> fetch_stall);

endmodule

bind irq_entry_seq irq_seq_checker #(.SP_W(SP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_done   (insn_done),
    .stk_we      (stk_we),
    .stk_re      (stk_re),
    .sp          (sp),
    .gie         (gie),
    .pc_load     (pc_load),
    .fetch_stall (fetch_stall)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic         insn_done = 1'b0;
    logic         reti_go = 1'b0;
    logic         sei_go = 1'b0;
    logic [15:0]  cur_pc = '0;
    logic [7:0]   stk_rdata;
    logic         stk_we, stk_re, gie, pc_load, fetch_stall;
    logic [7:0]   stk_addr, stk_wdata, sp;
    logic [15:0]  next_pc;

    logic [7:0]   mem [0:255];
    int           total = 0;
    int           bad = 0;

    always #2 clk = ~clk;

    irq_entry_seq #(.NUM_SRC(N)) dut (
        .clk (clk), .rst_n (rst_n), .irq_req (irq_req), .insn_done (insn_done),
        .reti_go (reti_go), .sei_go (sei_go), .cur_pc (cur_pc), .stk_rdata (stk_rdata),
        .stk_we (stk_we), .stk_re (stk_re), .stk_addr (stk_addr), .stk_wdata (stk_wdata),
        .sp (sp), .gie (gie), .next_pc (next_pc), .pc_load (pc_load), .fetch_stall (fetch_stall)
    );

    // stack memory model with synchronous read
    always @(posedge clk) begin
        if (stk_we) mem[stk_addr] <= stk_wdata;
        stk_rdata <= mem[stk_addr];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic raise(input logic [N-1:0] m);
        @(negedge clk); irq_req = m;
        @(negedge clk); irq_req = '0;
    endtask

    // retire with interrupt taken, then check the four response cycles
    task automatic entry_check(input int idx, input logic [15:0] pc, input bit glitch);
        logic [7:0] sp0;
        @(negedge clk);
        sp0 = sp;
        cur_pc = pc; insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0; cur_pc = ~pc;
        for (int j = 1; j <= 4; j++) begin
            chk("R4 stall", fetch_stall, 1'b1);
            if (j == 1) begin
                chk("R5 lo write", {stk_we, stk_addr, stk_wdata}, {1'b1, sp0, pc[7:0]});
            end else if (j == 3) begin
                chk("R5 hi write", {stk_we, stk_addr, stk_wdata}, {1'b1, sp0 - 8'd1, pc[15:8]});
            end else begin
                chk("R5 no access", stk_we, 1'b0);
            end
            if (j == 4) chk("R4 vector", {pc_load, next_pc}, {1'b1, 16'((idx + 1) << 1)});
            else        chk("R4 no load", pc_load, 1'b0);
            if (glitch && j == 2) begin
                insn_done = 1'b1; sei_go = 1'b1; reti_go = 1'b1;
            end else begin
                insn_done = 1'b0; sei_go = 1'b0; reti_go = 1'b0;
            end
            if (j != 4) @(negedge clk);
        end
        @(negedge clk);
        chk("R4 stall end", fetch_stall, 1'b0);
        chk("R5 sp after push", sp, sp0 - 8'd2);
        chk("R5 stack lo", mem[sp0], pc[7:0]);
        chk("R5 stack hi", mem[sp0 - 8'd1], pc[15:8]);
        chk(glitch ? "R10 gie" : "R6 gie cleared", gie, 1'b0);
    endtask

    task automatic ret_check(input logic [15:0] pc);
        logic [7:0] sp0;
        @(negedge clk);
        sp0 = sp;
        reti_go = 1'b1;
        @(negedge clk);
        reti_go = 1'b0;
        for (int j = 1; j <= 4; j++) begin
            chk("R7 stall", fetch_stall, 1'b1);
            if (j == 1)      chk("R7 hi read", {stk_re, stk_addr}, {1'b1, sp0 + 8'd1});
            else if (j == 3) chk("R7 lo read", {stk_re, stk_addr}, {1'b1, sp0 + 8'd2});
            else             chk("R7 no read", stk_re, 1'b0);
            if (j == 4) chk("R7 return pc", {pc_load, next_pc}, {1'b1, pc});
            else        chk("R7 no load", pc_load, 1'b0);
            if (j != 4) @(negedge clk);
        end
        @(negedge clk);
        chk("R7 sp after pop", sp, sp0 + 8'd2);
        chk("R7 gie set", gie, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sp", sp, 8'hFF);
        chk("R1 gie", gie, 1'b0);
        chk("R1 stall/load", {fetch_stall, pc_load}, 2'b00);
        chk("R1 stack idle", {stk_we, stk_re}, 2'b00);
        rst_n = 1'b1;

        // R6: disabled, retires do not take
        raise(4'b0001);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); insn_done = 1'b1;
            @(negedge clk); insn_done = 1'b0;
            chk("R6 no take while disabled", fetch_stall, 1'b0);
        end
        @(negedge clk); sei_go = 1'b1;
        @(negedge clk); sei_go = 1'b0;
        chk("R6 sei sets gie", gie, 1'b1);
        entry_check(0, 16'h0420, 1'b0);
        ret_check(16'h0420);

        // R2 sweep: each source with 0..2 cycles of outstanding instruction
        for (int idx = 0; idx < N; idx++) begin
            for (int d = 0; d < 3; d++) begin
                logic [15:0] pc;
                pc = 16'h1234 + 16'(idx * 16'h0111) + 16'(d);
                raise(4'(1 << idx));
                for (int w = 0; w < d; w++) begin
                    @(negedge clk);
                    chk("R2 wait for retire", fetch_stall, 1'b0);
                end
                entry_check(idx, pc, 1'b0);
                ret_check(pc);
            end
        end

        // R3 priority over every mask
        for (int m = 1; m < 16; m++) begin
            logic [3:0] rem;
            rem = 4'(m);
            raise(rem);
            for (int b = 0; b < N; b++) begin
                if (rem[b]) begin
                    entry_check(b, 16'hA000 + 16'(m * 16) + 16'(b), 1'b0);
                    ret_check(16'hA000 + 16'(m * 16) + 16'(b));
                    rem[b] = 1'b0;
                end
            end
            @(negedge clk);
            chk("R3 all drained", fetch_stall, 1'b0);
        end

        // R8: request inside handler waits for first retire after return
        raise(4'b0001);
        entry_check(0, 16'h3300, 1'b0);
        raise(4'b0100);
        @(negedge clk);
        chk("R8 no nesting while disabled", fetch_stall, 1'b0);
        ret_check(16'h3300);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk("R8 held until retire", fetch_stall, 1'b0);
        end
        entry_check(2, 16'h3302, 1'b0);
        ret_check(16'h3302);

        // R10: pulses during response ignored
        raise(4'b0011);
        entry_check(0, 16'h5A5A, 1'b1);
        chk("R10 no extra access", {stk_we, stk_re}, 2'b00);
        ret_check(16'h5A5A);
        entry_check(1, 16'h5A5C, 1'b0);
        ret_check(16'h5A5C);

        // R9 timer reading through entry
        begin
            int cnt;
            raise(4'b1000);
            @(negedge clk); cur_pc = 16'h0777; insn_done = 1'b1;
            cnt = 0;
            @(negedge clk); insn_done = 1'b0; cnt++;
            while (!pc_load && cnt < 20) begin
                @(negedge clk); cnt++;
            end
            repeat (2 + 11) begin
                @(negedge clk); cnt++;
            end
            chk("R9 timer count", 32'(cnt), 32'd17);
            ret_check(16'h0777);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule